// File: doc/BRIEF.md
# Global 64-bit Counter with Compare Channel

This block holds a free-running 64-bit up-counter and one 64-bit compare channel, all reached through a small 32-bit register bus. Software can read and load the counter one word at a time. It starts the count with a run bit and arms the comparator with an enable bit. When the counter equals the compare value, a sticky status flag is set. That flag drives the interrupt output through an enable mask.

With the auto-step bit clear, the channel is one-shot: the compare value stays where software put it. With the auto-step bit set, every match adds a programmed 32-bit step to the 64-bit compare value. The channel then keeps firing at a fixed period with no software reload. The counter has no snapshot latch. Software that needs a consistent 64-bit read reads the high word, then the low word, then the high word again, and repeats the sequence if the two high values differ.

Top module: `gcnt_cmp`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and `irq` is low.
- R2: While control bit 8 (run) is set, the counter rises by exactly one each clock; while it is clear, the counter holds.
- R3: Word address 0 is the counter's low 32 bits and address 1 its high 32 bits. A carry out of the low word reaches the high word. A write to either word loads that word, leaves the other unchanged and suppresses the increment for that clock.
- R4: While control bit 0 (compare enable) is set and the counter equals the 64-bit compare value (low word at address 2, high word at address 3), the status flag (bit 0 at address 6) reads 1 from the next clock on. While bit 0 is clear, equality sets nothing.
- R5: The status flag stays set until a write to address 6 with data bit 0 at 1. A write with bit 0 at 0 leaves it set. A match in the same clock as a clear leaves the flag set.
- R6: `irq` is high exactly when the status flag and bit 0 of the interrupt enable register (address 7) are both 1.
- R7: With control bit 1 (auto-step) set, each match adds the zero-extended 32-bit step register (address 4) to the compare value on the same clock edge that sets the flag. A bus write to a compare word in that clock takes precedence for that word.
- R8: With auto-step clear, a match leaves the compare value unchanged, so the flag is set once per equality.
- R9: The control register (address 5) reads back bits 0, 1 and 8 as written and all other bits as zero. The step and interrupt enable registers read back as written (enable: bit 0 only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | AW (3) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
Directed runs cover four cases:
- A counter loaded just below a low-word rollover, which separates a correct carry from a 32-bit wrap.
- A one-shot compare a few counts ahead, which shows the exact clock the flag rises and that the compare value stays put.
- An auto-step run, whose final compare value counts the matches.
- Equality with the comparator disabled, which shows that the enable gates the flag.

A constrained-random phase then writes compare values, counter words and steps within a few tens of counts of each other, so matches, set/clear collisions and write/re-arm collisions happen often. Every register and `irq` is compared each clock against a bench model.

// File: rtl/gcnt_cmp.sv
module gcnt_cmp #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CNT_LO = AW'(0);
  localparam logic [AW-1:0] A_CNT_HI = AW'(1);
  localparam logic [AW-1:0] A_CMP_LO = AW'(2);
  localparam logic [AW-1:0] A_CMP_HI = AW'(3);
  localparam logic [AW-1:0] A_STEP   = AW'(4);
  localparam logic [AW-1:0] A_CTRL   = AW'(5);
  localparam logic [AW-1:0] A_STAT   = AW'(6);
  localparam logic [AW-1:0] A_IEN    = AW'(7);
  localparam int B_CEN  = 0;
  localparam int B_AUTO = 1;
  localparam int B_RUN  = 8;

  logic [CW-1:0] cnt_q, cmp_q;
  logic [DW-1:0] step_q;
  logic run_q, auto_q, cen_q, stat_q, ien_q;

  logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_ctrl, wr_stat, wr_ien, wr_step;
  assign wr_cnt_lo = bus_wr && bus_addr == A_CNT_LO;
  assign wr_cnt_hi = bus_wr && bus_addr == A_CNT_HI;
  assign wr_cmp_lo = bus_wr && bus_addr == A_CMP_LO;
  assign wr_cmp_hi = bus_wr && bus_addr == A_CMP_HI;
  assign wr_step   = bus_wr && bus_addr == A_STEP;
  assign wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  assign wr_stat   = bus_wr && bus_addr == A_STAT;
  assign wr_ien    = bus_wr && bus_addr == A_IEN;

  logic match;
  assign match = cen_q && (cnt_q == cmp_q);

  logic [CW-1:0] cmp_next;
  assign cmp_next = cmp_q + {{DW{1'b0}}, step_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (wr_cnt_lo) cnt_q[DW-1:0] <= bus_wdata;
    else if (wr_cnt_hi) cnt_q[CW-1:DW] <= bus_wdata;
    else if (run_q)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else begin
      if (match && auto_q) cmp_q <= cmp_next;
      if (wr_cmp_lo) cmp_q[DW-1:0]  <= bus_wdata;
      if (wr_cmp_hi) cmp_q[CW-1:DW] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      run_q  <= 1'b0;
      auto_q <= 1'b0;
      cen_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_step) step_q <= bus_wdata;
      if (wr_ctrl) begin
        run_q  <= bus_wdata[B_RUN];
        auto_q <= bus_wdata[B_AUTO];
        cen_q  <= bus_wdata[B_CEN];
      end
      if (wr_ien) ien_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stat_q <= 1'b0;
    else if (match)                   stat_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) stat_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[DW-1:0];
      A_CNT_HI: bus_rdata = cnt_q[CW-1:DW];
      A_CMP_LO: bus_rdata = cmp_q[DW-1:0];
      A_CMP_HI: bus_rdata = cmp_q[CW-1:DW];
      A_STEP:   bus_rdata = step_q;
      A_CTRL: begin
        bus_rdata[B_RUN]  = run_q;
        bus_rdata[B_AUTO] = auto_q;
        bus_rdata[B_CEN]  = cen_q;
      end
      A_STAT:   bus_rdata[0] = stat_q;
      A_IEN:    bus_rdata[0] = ien_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = stat_q & ien_q;
endmodule

// File: rtl/gcnt_cmp_chk.sv
module gcnt_cmp_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [2*DW-1:0] cnt,
  input logic [2*DW-1:0] cmp,
  input logic [DW-1:0]   step,
  input logic            run,
  input logic            auto_on,
  input logic            cen,
  input logic            stat,
  input logic            ien,
  input logic            irq
);
  logic cnt_w, cmp_w, stat_clr, hit;
  assign cnt_w    = bus_wr && (bus_addr == AW'(0) || bus_addr == AW'(1));
  assign cmp_w    = bus_wr && (bus_addr == AW'(2) || bus_addr == AW'(3));
  assign stat_clr = bus_wr && bus_addr == AW'(6) && bus_wdata[0];
  assign hit      = cen && (cnt == cmp);

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_w |=> cnt == $past(cnt) + 1'b1);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_w |=> $stable(cnt));
  assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(0) |=> cnt[DW-1:0] == $past(bus_wdata) && cnt[2*DW-1:DW] == $past(cnt[2*DW-1:DW]));
  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat && !stat_clr |=> stat);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !hit |=> !stat);
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
  assert_autostep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && auto_on && !cmp_w |=> cmp == $past(cmp) + {{DW{1'b0}}, $past(step)});
  assert_oneshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_on && !cmp_w |=> $stable(cmp));
endmodule

bind gcnt_cmp gcnt_cmp_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt_q), .cmp(cmp_q), .step(step_q),
  .run(run_q), .auto_on(auto_q), .cen(cen_q), .stat(stat_q),
  .ien(ien_q), .irq(irq)
);

// File: tb/tb_gcnt_cmp.sv
module tb_gcnt_cmp;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gcnt_cmp #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step;
  logic m_run, m_auto, m_cen, m_stat, m_ien;
  wire  m_hit = m_cen && (m_cnt == m_cmp);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '0; m_step <= '0;
      m_run <= 0; m_auto <= 0; m_cen <= 0; m_stat <= 0; m_ien <= 0;
    end else begin
      // R3: a word write replaces the increment for that clock
      if (bus_wr && bus_addr == 3'd0)      m_cnt <= {m_cnt[63:32], bus_wdata};
      else if (bus_wr && bus_addr == 3'd1) m_cnt <= {bus_wdata, m_cnt[31:0]};
      else if (m_run)                      m_cnt <= m_cnt + 64'd1;
      // R7 / R8, with bus writes taking their word
      begin
        logic [63:0] nc;
        nc = (m_hit && m_auto) ? m_cmp + {32'd0, m_step} : m_cmp;
        if (bus_wr && bus_addr == 3'd2) nc[31:0]  = bus_wdata;
        if (bus_wr && bus_addr == 3'd3) nc[63:32] = bus_wdata;
        m_cmp <= nc;
      end
      if (bus_wr && bus_addr == 3'd4) m_step <= bus_wdata;
      if (bus_wr && bus_addr == 3'd5) begin
        m_run <= bus_wdata[8]; m_auto <= bus_wdata[1]; m_cen <= bus_wdata[0];
      end
      if (bus_wr && bus_addr == 3'd7) m_ien <= bus_wdata[0];
      if (m_hit) m_stat <= 1'b1;
      else if (bus_wr && bus_addr == 3'd6 && bus_wdata[0]) m_stat <= 1'b0;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[31:0];
      3'd1: return m_cnt[63:32];
      3'd2: return m_cmp[31:0];
      3'd3: return m_cmp[63:32];
      3'd4: return m_step;
      3'd5: return {23'd0, m_run, 6'd0, m_auto, m_cen};
      3'd6: return {31'd0, m_stat};
      default: return {31'd0, m_ien};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, then compare at the next negedge
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R9 readback", bus_rdata, exp_rd(a));
    check("R6 irq", {31'd0, irq}, {31'd0, m_stat & m_ien});
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'($urandom_range(0, 7)), 32'd0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R1 reset reg", v, 32'd0);
    end
    check("R1 irq low", {31'd0, irq}, 32'd0);
    idle(3);
    rd(3'd0, v); check("R1 R2 stopped counter", v, 32'd0);

    // R3 carry across the words
    cyc(1, 3'd0, 32'hFFFF_FFFD);
    cyc(1, 3'd1, 32'h0000_0012);
    cyc(1, 3'd5, 32'h0000_0100);
    idle(3);
    rd(3'd1, v); check("R3 carry high", v, 32'h13);
    rd(3'd0, v); check("R3 carry low", v, 32'h0);
    cyc(1, 3'd0, 32'h55);
    rd(3'd1, v); check("R3 low write keeps high", v, 32'h13);
    rd(3'd0, v); check("R3 low load no increment", v, 32'h55);
    idle(1);
    rd(3'd0, v); check("R2 increment", v, 32'h56);

    // R4 / R6 / R8 one-shot
    cyc(1, 3'd5, 32'h0);
    cyc(1, 3'd1, 32'h0);
    cyc(1, 3'd0, 32'd100);
    cyc(1, 3'd2, 32'd105);
    cyc(1, 3'd3, 32'd0);
    cyc(1, 3'd7, 32'd1);
    cyc(1, 3'd5, 32'h101);
    idle(5);
    rd(3'd6, v); check("R4 flag not yet", v, 32'd0);
    idle(1);
    rd(3'd6, v); check("R4 flag after match", v, 32'd1);
    check("R6 irq on", {31'd0, irq}, 32'd1);
    idle(10);
    rd(3'd2, v); check("R8 compare unchanged", v, 32'd105);
    cyc(1, 3'd6, 32'd0);
    rd(3'd6, v); check("R5 zero write ignored", v, 32'd1);
    cyc(1, 3'd7, 32'd0);
    check("R6 masked", {31'd0, irq}, 32'd0);
    cyc(1, 3'd6, 32'd1);
    rd(3'd6, v); check("R5 cleared", v, 32'd0);
    idle(5);
    rd(3'd6, v); check("R8 no second event", v, 32'd0);

    // R7 auto-step
    cyc(1, 3'd5, 32'h0);
    cyc(1, 3'd0, 32'd0);
    cyc(1, 3'd2, 32'd10);
    cyc(1, 3'd4, 32'd4);
    cyc(1, 3'd5, 32'h103);
    idle(20);
    rd(3'd2, v); check("R7 compare after three matches", v, 32'd22);

    // R4 disabled comparator
    cyc(1, 3'd5, 32'h0);
    cyc(1, 3'd6, 32'd1);
    cyc(1, 3'd0, 32'd50);
    cyc(1, 3'd2, 32'd52);
    cyc(1, 3'd5, 32'h100);
    idle(6);
    rd(3'd6, v); check("R4 disabled no flag", v, 32'd0);
    cyc(1, 3'd5, 32'hFFFF_FEFF);
    rd(3'd5, v); check("R9 ctrl mask", v, 32'h3);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) < 3) begin
        logic [2:0] a;
        logic [31:0] d;
        a = 3'($urandom_range(0, 7));
        case (a)
          3'd0: d = m_cmp[31:0] - $urandom_range(0, 20);
          3'd1: d = ($urandom_range(0, 1) != 0) ? m_cmp[63:32] : $urandom;
          3'd2: d = m_cnt[31:0] + $urandom_range(0, 30);
          3'd3: d = m_cnt[63:32];
          3'd4: d = $urandom_range(0, 15);
          3'd5: d = ($urandom & 32'hFFFF_FEFC) | ($urandom_range(0, 1) << 8) | $urandom_range(0, 3);
          default: d = $urandom;
        endcase
        cyc(1'b1, a, d);
      end else begin
        cyc(1'b0, 3'($urandom_range(0, 7)), 32'd0);
      end
    end
    summary();
  end
endmodule